// File: doc/BRIEF.md
# Multi-Lane Stream Lane Unpacker

The block takes one transfer at a time from a wide stream of several element lanes and hands the elements on one by one over a narrow, single-element stream. Each wide transfer carries the lane data, a start lane index, an end lane index, one strobe bit per lane and a last flag that closes a sequence. The block decides which lanes hold valid elements and emits them in ascending lane order. It raises the output last flag on the element that ends a sequence. A transfer that encodes an empty sequence becomes a single output beat flagged as empty.

Lane activity follows one fixed rule. When every strobe bit is high, the start and end indices mark an inclusive range of active lanes. When any strobe bit is low, the indices carry no meaning and the strobe bits alone pick the active lanes. A simple source that always drives start 0 and one shared strobe value therefore works unchanged. The wide input is held until its last active element has been taken downstream, so the input ready doubles as an end-of-unpacking indication. An inverted index range under full strobes is reported through a one-cycle error pulse.

Top module: `lane_unpacker`

## Requirements
- R1: When all strobe bits are high, the active lanes are start..end inclusive, and their elements appear on out_data in ascending lane order, one per accepted output beat.
- R2: When any strobe bit is low, start and end are ignored and exactly the lanes with a high strobe bit are emitted, lowest lane first (strobe 4'b1010 emits lane 1 then lane 3).
- R3: A transfer with all strobe bits low and last high produces exactly one output beat with out_empty=1, out_last=1 and out_data=0.
- R4: A transfer with no active lanes and last low is consumed in the cycle it is presented (in_ready high), with out_valid held low.
- R5: out_last is high only on the final active element of a transfer whose last flag is high, and on empty markers; it never rises for a transfer with last low.
- R6: in_ready rises only in the cycle that the final active element (or the empty marker) is accepted downstream, so the wide transfer is held through every output stall.
- R7: With all strobe bits high and start greater than end, the transfer has no active lanes and err_pulse is high for exactly the one cycle after it is accepted. If last is high it yields an empty marker; otherwise it is consumed silently. err_pulse is low after every other transfer.
- R8: While out_valid is high and out_ready is low, out_data and out_last hold their values into the next cycle.
- R9: During reset and with in_valid low, out_valid, in_ready and err_pulse are low.
- R10: A transfer with a single active lane is emitted and consumed in one cycle when out_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Wide transfer present |
| in_ready | output | 1 | Wide transfer consumed this cycle |
| in_data | input | LANES*ELEM_W | Lane data, lane i at bits i*ELEM_W upward |
| in_start | input | IDX_W | First active lane when all strobes are high |
| in_end | input | IDX_W | Last active lane when all strobes are high |
| in_strobe | input | LANES | Per-lane strobe, bit i for lane i |
| in_last | input | 1 | Transfer closes a sequence |
| out_valid | output | 1 | Output element or empty marker present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | ELEM_W | Selected element, zero on empty markers |
| out_last | output | 1 | Beat ends a sequence |
| out_empty | output | 1 | Beat is an empty-sequence marker |
| err_pulse | output | 1 | Inverted index range seen on the transfer just accepted |

## Verification
On every cycle the assertions check the handshake relations: output held under back-pressure, input ready only together with the closing output beat, last raised only on a beat that consumes the transfer, the shape of empty markers, idle outputs, and that the error pulse follows an accepted full-strobe transfer. The lane-selection rule itself, meaning which lanes are chosen, their order and their data, is shown only by the bench scenarios. These compare every beat with a lane model across full-range, partial-range, sparse-strobe, empty, silent, inverted-range and stalled transfers, plus a random mix.

// File: rtl/lane_unpacker_pkg.sv
package lane_unpacker_pkg;
    // What the output port carries in a given cycle.
    typedef enum logic [1:0] {
        BEAT_NONE  = 2'd0,
        BEAT_ELEM  = 2'd1,
        BEAT_EMPTY = 2'd2
    } beat_kind_e;
endpackage

// File: rtl/lane_activity_decode.sv
module lane_activity_decode #(
    parameter int LANES = 4,
    parameter int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] strobe,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] end_idx,
    output logic [LANES-1:0] active,
    output logic             inverted
);
    logic full_strobe;

    assign full_strobe = &strobe;
    assign inverted    = full_strobe && (start_idx > end_idx);

    // Per lane: range test under full strobes, own strobe bit otherwise.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [IDX_W-1:0] LANE_ID = IDX_W'(i);
        logic in_range;
        assign in_range  = (LANE_ID >= start_idx) && (LANE_ID <= end_idx);
        assign active[i] = full_strobe ? in_range : strobe[i];
    end
endmodule

// File: rtl/lane_pick.sv
module lane_pick #(
    parameter int LANES = 4,
    parameter int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] pending,
    output logic [IDX_W-1:0] idx,
    output logic             any,
    output logic             single
);
    // Lowest set lane wins.
    always_comb begin
        idx = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (pending[k]) begin
                idx = IDX_W'(k);
            end
        end
    end

    assign any    = |pending;
    assign single = any && ((pending & (pending - LANES'(1))) == '0);
endmodule

// File: rtl/lane_unpacker.sv
module lane_unpacker
    import lane_unpacker_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ELEM_W = 8,
    parameter int IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ELEM_W-1:0] in_data,
    input  logic [IDX_W-1:0]        in_start,
    input  logic [IDX_W-1:0]        in_end,
    input  logic [LANES-1:0]        in_strobe,
    input  logic                    in_last,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [ELEM_W-1:0]       out_data,
    output logic                    out_last,
    output logic                    out_empty,
    output logic                    err_pulse
);
    typedef struct packed {
        logic [LANES-1:0] sent;   // lanes of the held transfer already delivered
        logic             err;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0] active;
    logic             inverted;
    logic [LANES-1:0] pending;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_any;
    logic             pick_single;
    beat_kind_e       kind;
    logic             take_in;

    lane_activity_decode #(.LANES(LANES), .IDX_W(IDX_W)) u_decode (
        .strobe    (in_strobe),
        .start_idx (in_start),
        .end_idx   (in_end),
        .active    (active),
        .inverted  (inverted)
    );

    assign pending = active & ~st_q.sent;

    lane_pick #(.LANES(LANES), .IDX_W(IDX_W)) u_pick (
        .pending (pending),
        .idx     (pick_idx),
        .any     (pick_any),
        .single  (pick_single)
    );

    always_comb begin
        st_d = st_q;

        if (!in_valid) begin
            kind = BEAT_NONE;
        end else if (pick_any) begin
            kind = BEAT_ELEM;
        end else if (active == '0 && in_last) begin
            kind = BEAT_EMPTY;
        end else begin
            kind = BEAT_NONE;
        end

        out_valid = (kind != BEAT_NONE);
        out_empty = (kind == BEAT_EMPTY);
        out_data  = (kind == BEAT_ELEM) ? in_data[pick_idx*ELEM_W +: ELEM_W] : '0;
        out_last  = (kind == BEAT_EMPTY) ||
                    ((kind == BEAT_ELEM) && in_last && pick_single);

        take_in = ((kind == BEAT_ELEM) && pick_single && out_ready) ||
                  (in_valid && (active == '0) && (!in_last || out_ready));
        in_ready = take_in;

        st_d.err = take_in && inverted;
        if (take_in) begin
            st_d.sent = '0;
        end else if ((kind == BEAT_ELEM) && out_ready) begin
            st_d.sent = st_q.sent | (LANES'(1) << pick_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_pulse = st_q.err;
endmodule

// File: rtl/lane_unpacker_chk.sv
module lane_unpacker_chk #(
    parameter int LANES  = 4,
    parameter int ELEM_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic [LANES*ELEM_W-1:0] in_data,
    input logic [LANES-1:0]        in_strobe,
    input logic                    in_last,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [ELEM_W-1:0]       out_data,
    input logic                    out_last,
    input logic                    out_empty,
    input logic                    err_pulse
);
    // R8 (source side: a held transfer must not change)
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_ready |=> in_valid && $stable(in_data) &&
                                  $stable(in_strobe) && $stable(in_last));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !in_ready |=>
            out_valid && $stable(out_data) && $stable(out_last));

    // R3
    empty_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_empty |-> out_last && (out_data == '0));

    // R6
    ready_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && out_valid |-> out_ready && (out_last == in_last));

    // R5
    last_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |-> in_ready);

    // R7
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(in_valid && in_ready) && $past(&in_strobe));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !out_valid && !in_ready);
endmodule

bind lane_unpacker lane_unpacker_chk #(.LANES(LANES), .ELEM_W(ELEM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_strobe (in_strobe),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_empty (out_empty),
    .err_pulse (err_pulse)
);

// File: tb/sim_lane_unpacker.sv
`timescale 1ns/1ps
module sim_lane_unpacker;
    localparam int LANES  = 4;
    localparam int ELEM_W = 8;
    localparam int IDX_W  = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic [LANES*ELEM_W-1:0] in_data = '0;
    logic [IDX_W-1:0]        in_start = '0;
    logic [IDX_W-1:0]        in_end = '0;
    logic [LANES-1:0]        in_strobe = '0;
    logic                    in_last = 1'b0;
    logic                    out_valid;
    logic                    out_ready = 1'b0;
    logic [ELEM_W-1:0]       out_data;
    logic                    out_last;
    logic                    out_empty;
    logic                    err_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lane_unpacker #(.LANES(LANES), .ELEM_W(ELEM_W)) u0 (.*);

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Lane model written from R1/R2.
    function automatic logic [LANES-1:0] model_mask(input logic [LANES-1:0] stb,
                                                    input int st, input int en);
        logic [LANES-1:0] m = '0;
        if (stb == '1) begin
            for (int i = 0; i < LANES; i++) m[i] = (i >= st) && (i <= en);
        end else begin
            m = stb;
        end
        return m;
    endfunction

    // Presents one wide transfer and checks every beat it produces.
    task automatic run_xfer(input logic [31:0] data, input int st, input int en,
                            input logic [3:0] stb, input bit lst,
                            input logic [15:0] stall, input string tag);
        logic [LANES-1:0] m;
        logic [ELEM_W-1:0] exp_d [LANES];
        int n = 0;
        int k = 0;
        int cyc = 0;
        bit empty_exp, inv_exp, done, empty_seen;
        m = model_mask(stb, st, en);
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) begin
                exp_d[n] = data[i*ELEM_W +: ELEM_W];
                n++;
            end
        end
        empty_exp  = (n == 0) && lst;
        inv_exp    = (stb == 4'hF) && (st > en);
        done       = 0;
        empty_seen = 0;
        in_valid  = 1'b1;
        in_data   = data;
        in_start  = IDX_W'(st);
        in_end    = IDX_W'(en);
        in_strobe = stb;
        in_last   = lst;
        while (!done) begin
            out_ready = !stall[cyc % 16];
            @(negedge clk);
            if (out_valid && out_ready) begin
                if (empty_exp) begin
                    check(out_empty && out_last && out_data == 0,
                          {tag, " R3 empty marker (empty,last,data)"},
                          {out_empty, out_last, out_data}, 32'h300);
                    empty_seen = 1;
                end else if (k < n) begin
                    check(out_data == exp_d[k], {tag, " R1/R2 lane data in order"},
                          out_data, exp_d[k]);
                    check(out_last == (lst && k == n - 1), {tag, " R5 out_last"},
                          out_last, lst && k == n - 1);
                    check(!out_empty, {tag, " R3 no empty flag on element"}, out_empty, 0);
                    k++;
                end else begin
                    check(0, {tag, " R4/R1 unexpected output beat"}, 1, 0);
                end
            end
            if (in_ready) begin
                done = 1;
                check(k == n, {tag, " R6 in_ready only after final element"}, k, n);
                if (empty_exp) check(empty_seen, {tag, " R3 empty marker taken"}, empty_seen, 1);
                if (n == 0 && !lst) begin
                    check(cyc == 0 && !out_valid, {tag, " R4 silent consume in one cycle"},
                          cyc, 0);
                end
                if (n == 1 && stall[0] == 1'b0) begin
                    check(cyc == 0, {tag, " R10 single lane in one cycle"}, cyc, 0);
                end
            end
            @(posedge clk);
            #1;
            cyc++;
            if (cyc > 200) begin
                check(0, {tag, " R6 transfer never consumed"}, cyc, 0);
                done = 1;
            end
        end
        in_valid  = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        check(err_pulse == inv_exp, {tag, " R7 err_pulse after accept"}, err_pulse, inv_exp);
        check(!out_valid && !in_ready, {tag, " R9 idle after transfer"},
              {out_valid, in_ready}, 0);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !in_ready && !err_pulse, "R9 reset state",
              {out_valid, in_ready, err_pulse}, 0);
        #1 rst_n = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        check(!out_valid && !in_ready && !err_pulse, "R9 idle after reset",
              {out_valid, in_ready, err_pulse}, 0);
        @(posedge clk);
        #1;
    endtask

    task automatic t_full_range;   // R1: simple source, start 0, shared strobe
        run_xfer(32'h44332211, 0, 3, 4'hF, 1'b1, 16'h0, "full range R1");
        run_xfer(32'hA4A3A2A1, 1, 2, 4'hF, 1'b0, 16'h0, "partial range R1");
    endtask

    task automatic t_sparse;       // R2: indices ignored
        run_xfer(32'hD4C3B2A1, 3, 0, 4'b1010, 1'b1, 16'h0, "sparse R2");
        run_xfer(32'h5F6E7D8C, 2, 2, 4'b1001, 1'b0, 16'h0, "sparse ends R2");
    endtask

    task automatic t_empty;        // R3
        run_xfer(32'hFFFFFFFF, 0, 3, 4'h0, 1'b1, 16'h0002, "empty seq R3");
    endtask

    task automatic t_silent;       // R4
        run_xfer(32'h12345678, 0, 3, 4'h0, 1'b0, 16'h0, "silent R4");
    endtask

    task automatic t_inverted;     // R7
        run_xfer(32'h0BADF00D, 3, 1, 4'hF, 1'b0, 16'h0, "inverted no-last R7");
        run_xfer(32'h0BADF00D, 2, 0, 4'hF, 1'b1, 16'h0, "inverted last R7");
    endtask

    task automatic t_stall;        // R6 R8
        run_xfer(32'h9C8B7A69, 0, 3, 4'hF, 1'b1, 16'b0110_1101, "stalled R6 R8");
    endtask

    task automatic t_single;       // R10
        run_xfer(32'h00EE0000, 0, 3, 4'b0100, 1'b1, 16'h0, "single lane R10");
        run_xfer(32'h77000000, 3, 3, 4'hF, 1'b0, 16'h0, "single range R10");
    endtask

    task automatic t_random;       // R1 R2 R5 R6 mix
        for (int t = 0; t < 300; t++) begin
            logic [3:0] stb;
            int sel = $urandom_range(0, 3);
            stb = (sel < 2) ? 4'hF : ((sel == 2) ? 4'h0 : 4'($urandom));
            run_xfer($urandom, $urandom_range(0, 3), $urandom_range(0, 3), stb,
                     1'($urandom), 16'($urandom) & 16'h5555, "random R1/R2");
        end
    endtask

    initial begin
        #(2_000_000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_full_range();
        t_sparse();
        t_empty();
        t_silent();
        t_inverted();
        t_stall();
        t_single();
        t_random();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule